// File: doc/BRIEF.md
# PWM Action Qualifier

This block converts time-base event strobes into two registered PWM levels, A and B. Each output owns a separate table that maps every event source to a 2-bit action: hold, drive low, drive high or toggle. The sources are counter zero, counter period, compare A, compare B and two auxiliary triggers. Compare and trigger strobes are split into an up-count event and a down-count event by the count direction input.

The tables are loaded one entry per cycle through a small configuration bus. When several events fire in the same cycle, a fixed priority picks the action that is applied. A per-output one-shot force can replace the table result for a single cycle, so software can set, clear or toggle a level at once.

Top module: `pwm_action_qual`

## Requirements
- R1: While reset is asserted, and after it is released with no further stimulus, both outputs are low. All table entries reset to hold (00).
- R2: Event indices are 0 zero, 1 period, 2 compare A up, 3 compare A down, 4 compare B up, 5 compare B down, 6 trigger 1 up, 7 trigger 1 down, 8 trigger 2 up, 9 trigger 2 down. A zero or period strobe applies the action that output's own table holds for that index. A and B are independent: cfg_sel_i 0 writes the table of A and 1 writes the table of B.
- R3: The action codes are 00 hold, 01 drive low, 10 drive high and 11 toggle.
- R4: A compare A strobe uses index 2 when dir_up_i is 1 and index 3 when dir_up_i is 0.
- R5: A compare B strobe uses index 4 when dir_up_i is 1 and index 5 when dir_up_i is 0.
- R6: Trigger 1 uses index 6 on up-count and index 7 on down-count. Trigger 2 uses index 8 on up-count and index 9 on down-count.
- R7: Among the events that fire in the same cycle with a non-hold action, the higher index wins. This gives the order trigger 2 over trigger 1 over compare B over compare A over period over zero. A firing event whose action is hold does not block a lower-ranked one.
- R8: frc_req_i bit 0 (A) or bit 1 (B) applies frc_act_i, with the R3 codes, to that output in place of any table result for that cycle. Code 00 holds the output even when events fire.
- R9: An event or force sampled at a rising clock edge shows at the output right after that edge. A table write takes effect at the edge it is sampled on, so an event in the same cycle still uses the old entry.
- R10: A configuration write with cfg_evt_i of 10 or more changes no table entry.
- R11: In a cycle with no event strobe and no force request for an output, that output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_up_i | input | 1 | Count direction: 1 up, 0 down |
| zero_i | input | 1 | Counter-equals-zero strobe |
| period_i | input | 1 | Counter-equals-period strobe |
| cmpa_i | input | 1 | Compare A match strobe |
| cmpb_i | input | 1 | Compare B match strobe |
| trig1_i | input | 1 | Auxiliary trigger 1 strobe |
| trig2_i | input | 1 | Auxiliary trigger 2 strobe |
| cfg_we_i | input | 1 | Table write enable |
| cfg_sel_i | input | 1 | Table select: 0 output A, 1 output B |
| cfg_evt_i | input | 4 | Event index of the entry written |
| cfg_act_i | input | 2 | Action code written |
| frc_req_i | input | 2 | One-shot force request, bit 0 A, bit 1 B |
| frc_act_i | input | 2 | Action code used by a force |
| pwm_a_o | output | 1 | Output level A |
| pwm_b_o | output | 1 | Output level B |

## Verification
Every result of this block is due exactly one clock edge after the stimulus: an event or force driven before edge n shows on the outputs just after edge n. A table write made before edge n is seen first by events driven before edge n+1. The driver changes inputs on the falling edge and queues the level pair it expects after the next rising edge. The monitor compares two nanoseconds after that rising edge, so every check lands on the cycle its requirement fixes. Same-cycle write-plus-event and multi-event cycles are included to catch results that arrive a cycle early or late.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  localparam int unsigned ACT_W     = 2;
  localparam int unsigned NUM_DIRSRC = 4;  // cmpa, cmpb, trig1, trig2
  localparam int unsigned NUM_EVT   = 2 + 2 * NUM_DIRSRC;
  localparam int unsigned EVT_IDX_W = $clog2(NUM_EVT);
  localparam int unsigned NUM_OUT   = 2;

  function automatic logic apply_act(input logic cur, input logic [ACT_W-1:0] act);
    case (aq_act_e'(act))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_evt_decode.sv
module pwm_aq_evt_decode
  import pwm_aq_pkg::*;
(
  input  logic                  dir_up_i,
  input  logic                  zero_i,
  input  logic                  period_i,
  input  logic [NUM_DIRSRC-1:0] src_i,   // ascending priority
  output logic [NUM_EVT-1:0]    evt_o
);
  assign evt_o[0] = zero_i;
  assign evt_o[1] = period_i;

  for (genvar k = 0; k < NUM_DIRSRC; k++) begin : g_dir
    assign evt_o[2 + 2*k] = src_i[k] &  dir_up_i;
    assign evt_o[3 + 2*k] = src_i[k] & ~dir_up_i;
  end
endmodule

// File: rtl/pwm_aq_table.sv
module pwm_aq_table
  import pwm_aq_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned IDX_W = EVT_IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [ACT_W-1:0]            act_i,
  output logic [N_EVT-1:0][ACT_W-1:0] tbl_o
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             tbl_o[g] <= ACT_HOLD;
      else if (we_i && idx_i == IDX_W'(g))     tbl_o[g] <= act_i;
    end
  end
endmodule

// File: rtl/pwm_aq_resolve.sv
module pwm_aq_resolve
  import pwm_aq_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT
) (
  input  logic [N_EVT-1:0]            evt_i,
  input  logic [N_EVT-1:0][ACT_W-1:0] tbl_i,
  output logic [ACT_W-1:0]            act_o
);
  // higher index overrides lower; hold entries never win
  always_comb begin
    act_o = ACT_HOLD;
    for (int i = 0; i < N_EVT; i++) begin
      if (evt_i[i] && tbl_i[i] != ACT_HOLD) act_o = tbl_i[i];
    end
  end
endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACT_W-1:0] evt_act_i,
  input  logic             frc_i,
  input  logic [ACT_W-1:0] frc_act_i,
  output logic             lvl_o
);
  logic [ACT_W-1:0] act_sel;
  logic             lvl_nxt;

  assign act_sel = frc_i ? frc_act_i : evt_act_i;
  assign lvl_nxt = apply_act(lvl_o, act_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= 1'b0;
    else         lvl_o <= lvl_nxt;
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dir_up_i,
  input  logic                 zero_i,
  input  logic                 period_i,
  input  logic                 cmpa_i,
  input  logic                 cmpb_i,
  input  logic                 trig1_i,
  input  logic                 trig2_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_sel_i,
  input  logic [EVT_IDX_W-1:0] cfg_evt_i,
  input  logic [ACT_W-1:0]     cfg_act_i,
  input  logic [NUM_OUT-1:0]   frc_req_i,
  input  logic [ACT_W-1:0]     frc_act_i,
  output logic                 pwm_a_o,
  output logic                 pwm_b_o
);
  logic [NUM_EVT-1:0]    evt;
  logic [NUM_DIRSRC-1:0] dsrc;
  logic [NUM_OUT-1:0]    lvl;

  assign dsrc = {trig2_i, trig1_i, cmpb_i, cmpa_i};

  pwm_aq_evt_decode u_dec (
    .dir_up_i (dir_up_i),
    .zero_i   (zero_i),
    .period_i (period_i),
    .src_i    (dsrc),
    .evt_o    (evt)
  );

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_ch
    logic [NUM_EVT-1:0][ACT_W-1:0] tbl;
    logic [ACT_W-1:0]              evt_act;
    logic                          we;

    assign we = cfg_we_i && (cfg_sel_i == 1'(c));

    pwm_aq_table #(.N_EVT(NUM_EVT), .IDX_W(EVT_IDX_W)) u_tbl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .idx_i  (cfg_evt_i),
      .act_i  (cfg_act_i),
      .tbl_o  (tbl)
    );

    pwm_aq_resolve #(.N_EVT(NUM_EVT)) u_res (
      .evt_i (evt),
      .tbl_i (tbl),
      .act_o (evt_act)
    );

    pwm_aq_out u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_act_i (evt_act),
      .frc_i     (frc_req_i[c]),
      .frc_act_i (frc_act_i),
      .lvl_o     (lvl[c])
    );
  end

  assign pwm_a_o = lvl[0];
  assign pwm_b_o = lvl[1];
endmodule

// File: rtl/pwm_action_qual_chk.sv
module pwm_action_qual_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       zero_i,
  input logic       period_i,
  input logic       cmpa_i,
  input logic       cmpb_i,
  input logic       trig1_i,
  input logic       trig2_i,
  input logic [1:0] frc_req_i,
  input logic [1:0] frc_act_i,
  input logic       pwm_a_o,
  input logic       pwm_b_o
);
  logic quiet;
  assign quiet = !(zero_i || period_i || cmpa_i || cmpb_i || trig1_i || trig2_i);

  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && !frc_req_i[0] |=> $stable(pwm_a_o)); // R11
  AST_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && !frc_req_i[1] |=> $stable(pwm_b_o)); // R11
  AST_FRC_HIGH_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_req_i[0] && frc_act_i == 2'b10 |=> pwm_a_o); // R8
  AST_FRC_LOW_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_req_i[1] && frc_act_i == 2'b01 |=> !pwm_b_o); // R8
  AST_FRC_TGL_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_req_i[0] && frc_act_i == 2'b11 |=> pwm_a_o != $past(pwm_a_o)); // R8
  AST_FRC_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_req_i[1] && frc_act_i == 2'b00 |=> $stable(pwm_b_o)); // R8
endmodule

bind pwm_action_qual pwm_action_qual_chk u_chk (.*);

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dir_up_i = 1'b1;
  logic       zero_i = 1'b0, period_i = 1'b0, cmpa_i = 1'b0, cmpb_i = 1'b0;
  logic       trig1_i = 1'b0, trig2_i = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [3:0] cfg_evt_i = '0;
  logic [1:0] cfg_act_i = '0, frc_req_i = '0, frc_act_i = '0;
  logic       pwm_a_o, pwm_b_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pwm_action_qual dut_i (.*);

  typedef struct { logic a; logic b; string tag; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_tab [2][10];
  logic       m_out [2];

  function automatic logic app(logic cur, logic [1:0] act);
    case (act)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic check(logic ok, string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual a/b=%b expected a/b=%b", tag, act, exp);
    end
  endtask

  task automatic step(logic z, logic p, logic ca, logic cb, logic t1, logic t2, logic up,
                      logic we, logic sel, logic [3:0] idx, logic [1:0] act,
                      logic [1:0] fq, logic [1:0] fa, string tag);
    logic [9:0] evv;
    logic [1:0] res;
    exp_t e;
    @(negedge clk_i);
    zero_i = z; period_i = p; cmpa_i = ca; cmpb_i = cb; trig1_i = t1; trig2_i = t2;
    dir_up_i = up; cfg_we_i = we; cfg_sel_i = sel; cfg_evt_i = idx; cfg_act_i = act;
    frc_req_i = fq; frc_act_i = fa;
    evv = {t2 & ~up, t2 & up, t1 & ~up, t1 & up, cb & ~up, cb & up, ca & ~up, ca & up, p, z};
    for (int ch = 0; ch < 2; ch++) begin
      res = 2'b00;
      for (int i = 0; i < 10; i++)
        if (evv[i] && m_tab[ch][i] != 2'b00) res = m_tab[ch][i];
      if (fq[ch]) res = fa;
      m_out[ch] = app(m_out[ch], res);
    end
    if (we && idx < 4'd10) m_tab[sel][idx] = act;
    e.a = m_out[0]; e.b = m_out[1]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(logic sel, logic [3:0] idx, logic [1:0] act, string tag);
    step(0,0,0,0,0,0,1, 1,sel,idx,act, 2'b00,2'b00, tag);
  endtask

  task automatic ev(logic z, logic p, logic ca, logic cb, logic t1, logic t2, logic up, string tag);
    step(z,p,ca,cb,t1,t2,up, 0,0,4'd0,2'b00, 2'b00,2'b00, tag);
  endtask

  task automatic frc(logic [1:0] fq, logic [1:0] fa, logic z, string tag);
    step(z,0,0,0,0,0,1, 0,0,4'd0,2'b00, fq,fa, tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(pwm_a_o === e.a && pwm_b_o === e.b, e.tag, {pwm_a_o, pwm_b_o}, {e.a, e.b});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_out[c] = 1'b0;
      for (int i = 0; i < 10; i++) m_tab[c][i] = 2'b00;
    end
    repeat (3) @(posedge clk_i);
    #1 check(!pwm_a_o && !pwm_b_o, "R1 in reset", {pwm_a_o, pwm_b_o}, 2'b00);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 check(!pwm_a_o && !pwm_b_o, "R1 after release", {pwm_a_o, pwm_b_o}, 2'b00);

    ev(1,1,1,1,1,1,1, "R1 empty tables hold");
    ev(0,0,0,0,0,0,1, "R11 idle");
    // independent tables
    wr(0, 4'd0, 2'b10, "R2 cfg");
    wr(1, 4'd0, 2'b01, "R2 cfg");
    wr(0, 4'd1, 2'b01, "R2 cfg");
    wr(1, 4'd1, 2'b10, "R2 cfg");
    ev(1,0,0,0,0,0,1, "R2 zero");
    ev(0,1,0,0,0,0,1, "R2 period");
    ev(0,0,0,0,0,0,0, "R11 idle");
    // compare A by direction, toggle
    wr(0, 4'd2, 2'b11, "R3 cfg");
    ev(0,0,1,0,0,0,1, "R3 toggle");
    ev(0,0,1,0,0,0,1, "R3 toggle");
    ev(0,0,1,0,0,0,1, "R4 up toggle");
    ev(0,0,1,0,0,0,0, "R4 down hold");
    wr(0, 4'd3, 2'b01, "R4 cfg");
    ev(0,0,1,0,0,0,0, "R4 down low");
    ev(0,0,1,0,0,0,1, "R4 up");
    // compare B
    wr(1, 4'd4, 2'b01, "R5 cfg");
    wr(1, 4'd5, 2'b10, "R5 cfg");
    ev(0,0,0,1,0,0,1, "R5 up low");
    ev(0,0,0,1,0,0,0, "R5 down high");
    ev(0,0,0,1,0,0,1, "R5 up low again");
    // triggers
    wr(0, 4'd6, 2'b10, "R6 cfg");
    wr(0, 4'd7, 2'b01, "R6 cfg");
    wr(0, 4'd8, 2'b11, "R6 cfg");
    wr(1, 4'd9, 2'b10, "R6 cfg");
    ev(0,0,0,0,1,0,1, "R6 t1 up");
    ev(0,0,0,0,1,0,0, "R6 t1 down");
    ev(0,0,0,0,0,1,1, "R6 t2 up");
    ev(0,0,0,0,0,1,0, "R6 t2 down");
    ev(0,0,0,0,0,1,1, "R6 t2 up");
    // priority
    wr(0, 4'd0, 2'b10, "R7 cfg");
    ev(1,0,1,0,0,0,0, "R7 ca over zero");
    wr(0, 4'd4, 2'b10, "R7 cfg");
    ev(0,0,1,1,0,0,1, "R7 cb over ca");
    wr(0, 4'd4, 2'b01, "R7 cfg");
    ev(0,0,0,1,1,0,1, "R7 t1 over cb");
    ev(0,0,0,0,1,1,1, "R7 t2 over t1");
    ev(1,1,0,0,0,0,1, "R7 period over zero");
    ev(0,0,1,0,0,1,0, "R7 hold entry skipped");
    ev(0,1,0,1,0,1,0, "R7 mixed");
    // force
    wr(0, 4'd0, 2'b01, "R8 cfg");
    frc(2'b01, 2'b10, 1, "R8 force high over table");
    frc(2'b10, 2'b01, 1, "R8 force low B");
    frc(2'b01, 2'b11, 0, "R8 force toggle");
    frc(2'b11, 2'b11, 0, "R8 force toggle both");
    frc(2'b11, 2'b00, 1, "R8 force hold");
    frc(2'b00, 2'b00, 1, "R8 table after force");
    // same-cycle write and event
    step(1,0,0,0,0,0,1, 1,0,4'd0,2'b10, 2'b00,2'b00, "R9 old entry used");
    ev(0,0,0,0,0,0,1, "R9 idle");
    ev(1,0,0,0,0,0,1, "R9 new entry");
    // invalid index
    wr(0, 4'd12, 2'b11, "R10 cfg");
    wr(1, 4'd10, 2'b11, "R10 cfg");
    wr(0, 4'd15, 2'b10, "R10 cfg");
    ev(0,0,0,1,0,0,1, "R10 cb up unchanged");
    ev(0,0,1,0,0,0,0, "R10 ca down unchanged");
    ev(1,1,0,0,0,0,1, "R10 zero/period unchanged");
    ev(0,0,0,0,0,0,1, "R11 final idle");
    repeat (3) @(posedge clk_i);
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule